// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block gathers the interrupt requests of one UART channel into a single interrupt line. It keeps a four-bit source register fed by one-cycle event pulses from the receive path, the transmit path, the error detector and the modem-status logic. A mask register selects which sources may reach the interrupt output. The masked view of the source register is readable as its own register.

The transmit request also regenerates by itself. While the FIFOs are enabled, the block compares the transmit FIFO occupancy with a threshold. The threshold is a three-bit field multiplied by a per-channel scale factor that is fixed when the design is built. If the occupancy is at or below the threshold, the transmit source bit is set again every cycle. A small word-addressed register port lets software program the FIFO control fields and the mask, read all four registers, and clear source bits by writing ones.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source, mask and FIFO-control registers are all zero. Every register reads zero and `irq` is low.
- R2: A pulse on `ev_rx`, `ev_err`, `ev_tx` or `ev_modem` sets source bit 0, 1, 2 or 3 respectively at the next rising clock edge. A source bit never becomes set without such a cause.
- R3: The masked-pending value (address 2) equals source AND NOT mask. `irq` is high exactly when that value is nonzero.
- R4: Writing to address 2 clears every source bit whose `reg_wdata` bit is one, and so clears the matching masked-pending bits too. Other source bits keep their value.
- R5: Writing to address 1 clears every source bit whose `reg_wdata` bit is one. Other source bits keep their value.
- R6: If a bit is set and cleared in the same cycle, the set wins and the bit stays one.
- R7: FIFO enable is FIFO-control bit 0 (address 0). While it is one and `tx_count` is less than or equal to the transmit threshold, source bit 2 is set every cycle. While it is zero, the occupancy has no effect.
- R8: The transmit threshold is FIFO-control bits [10:8] times a scale factor. The factor is 32 for `CHANNEL` 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. Any other channel gives a threshold of 0. The receive trigger field, bits [6:4], is stored but has no effect on any source bit.
- R9: A write to the mask register (address 3) changes `irq` right after the clock edge that takes the write.
- R10: Address 0 reads back bits 0, [6:4] and [10:8] as written, and all other bits as zero. Address 3 reads back the four mask bits, and all other bits as zero. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 FIFO control, 1 source, 2 masked pending, 3 mask |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_modem | input | 1 | Modem-status event pulse |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| irq | output | 1 | Interrupt request |

## Verification
A wrong source bit shows up in the source and masked-pending readback, and in `irq`, on the clock edge after the cause. A wrong threshold shows up as source bit 2 surviving a clear, or failing to survive one, so the bench sweeps every field value against every occupancy on three channel variants and reads the result right after the clearing edge. A faulty mask register shows in the masked-pending readback and in `irq` one edge after the mask write. The bench checks all 256 source and mask combinations.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;

  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [1:0] {
    RA_FIFOCTL = 2'd0,
    RA_SRC     = 2'd1,
    RA_PEND    = 2'd2,
    RA_MASK    = 2'd3
  } reg_addr_e;

  // Multiplier applied to the transmit trigger field for a given channel.
  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] trig_level(input logic [2:0] fld,
                                             input int unsigned scale);
    return 32'(fld) * scale;
  endfunction
endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fifoctl,
  input  logic               wr_mask,
  input  logic               fifo_en_d,
  input  logic [2:0]         rx_fld_d,
  input  logic [2:0]         tx_fld_d,
  input  logic [NUM_SRC-1:0] mask_d,
  output logic               fifo_en,
  output logic [2:0]         rx_fld,
  output logic [2:0]         tx_fld,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      rx_fld  <= '0;
      tx_fld  <= '0;
    end else if (wr_fifoctl) begin
      fifo_en <= fifo_en_d;
      rx_fld  <= rx_fld_d;
      tx_fld  <= tx_fld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end
endmodule

// File: rtl/uart_irq_txlvl.sv
module uart_irq_txlvl
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             fifo_en,
  input  logic [2:0]       tx_fld,
  input  logic [CNT_W-1:0] tx_count,
  output logic             tx_hit
);
  localparam int unsigned SCALE = trig_scale(CHANNEL);

  generate
    if (SCALE == 0) begin : g_zero
      // Threshold is fixed at zero: only an empty FIFO qualifies.
      logic unused_fld;
      assign unused_fld = ^tx_fld;
      assign tx_hit = fifo_en && (tx_count == '0);
    end else begin : g_scaled
      logic [31:0] level;
      assign level  = trig_level(tx_fld, SCALE);
      assign tx_hit = fifo_en && (32'(tx_count) <= level);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] src_q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx,
  input  logic              ev_modem,
  input  logic [CNT_W-1:0]  tx_count,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - 11;

  logic               wr_fifoctl, wr_src, wr_pend, wr_mask;
  logic               fifo_en, tx_hit;
  logic [2:0]         rx_fld, tx_fld;
  logic [NUM_SRC-1:0] mask_q, src_q, pend, set_vec, clr_vec, ev_vec;
  logic               unused_wbits;

  assign unused_wbits = ^{reg_wdata[DATA_W-1:11], reg_wdata[7]};

  assign wr_fifoctl = reg_wr && (reg_addr == RA_FIFOCTL);
  assign wr_src     = reg_wr && (reg_addr == RA_SRC);
  assign wr_pend    = reg_wr && (reg_addr == RA_PEND);
  assign wr_mask    = reg_wr && (reg_addr == RA_MASK);

  uart_irq_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fifoctl (wr_fifoctl),
    .wr_mask    (wr_mask),
    .fifo_en_d  (reg_wdata[0]),
    .rx_fld_d   (reg_wdata[6:4]),
    .tx_fld_d   (reg_wdata[10:8]),
    .mask_d     (reg_wdata[NUM_SRC-1:0]),
    .fifo_en    (fifo_en),
    .rx_fld     (rx_fld),
    .tx_fld     (tx_fld),
    .mask_q     (mask_q)
  );

  uart_irq_txlvl #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_txlvl (
    .fifo_en  (fifo_en),
    .tx_fld   (tx_fld),
    .tx_count (tx_count),
    .tx_hit   (tx_hit)
  );

  always_comb begin
    ev_vec            = '0;
    ev_vec[SRC_RX]    = ev_rx;
    ev_vec[SRC_ERR]   = ev_err;
    ev_vec[SRC_TX]    = ev_tx;
    ev_vec[SRC_MODEM] = ev_modem;
    set_vec           = ev_vec;
    set_vec[SRC_TX]   = ev_tx | tx_hit;
  end

  // Writes to either pending view clear source bits.
  assign clr_vec = (wr_src || wr_pend) ? reg_wdata[NUM_SRC-1:0] : '0;

  uart_irq_src u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .src_q   (src_q)
  );

  assign pend = src_q & ~mask_q;
  assign irq  = |pend;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_FIFOCTL: reg_rdata = {{PAD_W{1'b0}}, tx_fld, 1'b0, rx_fld, 3'b000, fifo_en};
      RA_SRC:     reg_rdata[NUM_SRC-1:0] = src_q;
      RA_PEND:    reg_rdata[NUM_SRC-1:0] = pend;
      RA_MASK:    reg_rdata[NUM_SRC-1:0] = mask_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src,
  input logic [3:0] mask,
  input logic [3:0] set_vec,
  input logic [3:0] clr_vec,
  input logic       tx_hit,
  input logic       irq
);
  p_irq_follows_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(src & ~mask)));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 4'b0) |=> ((src & $past(set_vec)) == $past(set_vec)));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src & ~$past(src) & ~$past(set_vec)) == 4'b0));

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 4'b0) |=> ((src & $past(clr_vec & ~set_vec)) == 4'b0));

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & set_vec) != 4'b0) |=> ((src & $past(clr_vec & set_vec)) == $past(clr_vec & set_vec)));

  p_tx_regen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |=> src[2]);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src     (src_q),
  .mask    (mask_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .tx_hit  (tx_hit),
  .irq     (irq)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        ev_rx = 1'b0, ev_err = 1'b0, ev_tx = 1'b0, ev_modem = 1'b0;
  logic [7:0]  tx_count = '0;
  logic [31:0] rd0, rd3, rd6;
  logic        irq0, irq3, irq6;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd0), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx(ev_tx), .ev_modem(ev_modem), .tx_count(tx_count), .irq(irq0));
  uart_irq_ctrl #(.CHANNEL(3)) i_uart_irq_ctrl_c3 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd3), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx(ev_tx), .ev_modem(ev_modem), .tx_count(tx_count), .irq(irq3));
  uart_irq_ctrl #(.CHANNEL(6)) i_uart_irq_ctrl_c6 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd6), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx(ev_tx), .ev_modem(ev_modem), .tx_count(tx_count), .irq(irq6));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle with optional events and write; returns on the following falling edge.
  task automatic step(input logic [3:0] ev, input bit w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    {ev_modem, ev_tx, ev_err, ev_rx} = ev;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    {ev_modem, ev_tx, ev_err, ev_rx} = 4'b0;
    reg_wr = 1'b0;
  endtask

  task automatic rd_all(input logic [1:0] a);
    reg_addr = a;
    #1;
  endtask

  function automatic logic [31:0] lvl(input int ch, input logic [2:0] f);
    if (ch == 0) return 32'(f) << 5;
    if (ch == 3) return 32'(f) + 32'(f);
    return 32'd0;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_all(a[1:0]);
      check("R1 rd ch0", rd0, 0);
      check("R1 rd ch3", rd3, 0);
      check("R1 rd ch6", rd6, 0);
    end
    check("R1 irq", {29'd0, irq0, irq3, irq6}, 0);

    // R10 readback of written fields
    step(4'b0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    rd_all(2'd0); check("R10 fifoctl readback", rd0, 32'h771);
    step(4'b0, 1'b1, 2'd3, 32'hFFFF_FFFF);
    rd_all(2'd3); check("R10 mask readback", rd0, 32'hF);
    rd_all(2'd3); check("R10 read no side effect", rd0, 32'hF);

    // R2 and R3: every source and mask combination, FIFO disabled
    step(4'b0, 1'b1, 2'd0, 32'h0);
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        step(4'b0, 1'b1, 2'd1, 32'hF);
        step(s[3:0], 1'b0, 2'd0, 32'h0);
        step(4'b0, 1'b1, 2'd3, 32'(m));
        rd_all(2'd1); check("R2 source bits", rd0, 32'(s));
        rd_all(2'd2); check("R3 masked pending", rd0, 32'(s & ~m & 15));
        check("R3 irq", {31'd0, irq0}, {31'd0, (s & ~m & 15) != 0});
      end
    end

    // R9 mask write takes effect on the next edge
    step(4'b0, 1'b1, 2'd3, 32'h0);
    step(4'b0, 1'b1, 2'd1, 32'hF);
    step(4'b0001, 1'b0, 2'd0, 32'h0);
    check("R9 irq before mask", {31'd0, irq0}, 1);
    step(4'b0, 1'b1, 2'd3, 32'h1);
    check("R9 irq after mask", {31'd0, irq0}, 0);
    step(4'b0, 1'b1, 2'd3, 32'h0);

    // R5 partial clear through the source address
    step(4'b1111, 1'b0, 2'd0, 32'h0);
    step(4'b0, 1'b1, 2'd1, 32'h6);
    rd_all(2'd1); check("R5 partial clear", rd0, 32'h9);

    // R4 clear through the masked-pending address
    step(4'b1111, 1'b0, 2'd0, 32'h0);
    step(4'b0, 1'b1, 2'd2, 32'h5);
    rd_all(2'd1); check("R4 source after pend clear", rd0, 32'hA);
    rd_all(2'd2); check("R4 pend after pend clear", rd0, 32'hA);

    // R6 set wins over clear, both addresses
    step(4'b0, 1'b1, 2'd1, 32'hF);
    step(4'b0001, 1'b1, 2'd1, 32'hF);
    rd_all(2'd1); check("R6 set beats source clear", rd0, 32'h1);
    step(4'b1000, 1'b1, 2'd2, 32'hF);
    rd_all(2'd1); check("R6 set beats pend clear", rd0, 32'h8);

    // R7 disabled FIFO: occupancy is ignored
    step(4'b0, 1'b1, 2'd0, 32'h700);
    tx_count = 8'd0;
    step(4'b0, 1'b1, 2'd1, 32'hF);
    rd_all(2'd1);
    check("R7 disabled ch0", rd0, 0);
    check("R7 disabled ch3", rd3, 0);
    check("R7 disabled ch6", rd6, 0);

    // R8 receive field has no effect; transmit field 0 gives threshold 0
    step(4'b0, 1'b1, 2'd0, 32'h071);
    tx_count = 8'd1;
    step(4'b0, 1'b1, 2'd1, 32'hF);
    rd_all(2'd1);
    check("R8 rx field ignored ch0", rd0, 0);
    check("R8 rx field ignored ch3", rd3, 0);
    tx_count = 8'd0;
    step(4'b0, 1'b1, 2'd1, 32'hF);
    rd_all(2'd1);
    check("R8 zero level empty ch6", rd6, 32'h4);

    // R7 and R8 sweep of trigger field against occupancy
    for (int f = 0; f < 8; f++) begin
      step(4'b0, 1'b1, 2'd0, 32'(f << 8) | 32'h1);
      for (int c = 0; c < 256; c++) begin
        tx_count = c[7:0];
        step(4'b0, 1'b1, 2'd1, 32'hF);
        rd_all(2'd1);
        check("R8 level ch0", rd0, (32'(c) <= lvl(0, f[2:0])) ? 32'h4 : 32'h0);
        check("R8 level ch3", rd3, (32'(c) <= lvl(3, f[2:0])) ? 32'h4 : 32'h0);
        check("R8 level ch6", rd6, (32'(c) <= lvl(6, f[2:0])) ? 32'h4 : 32'h0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule